// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

This block chooses which of two reference clocks feeds a downstream reference path. Input 0 is the primary and input 1 is the backup. A free-running system clock runs the supervision logic. Each reference input drives a toggle flag, and that flag is synchronized into the system domain. A fixed-length observation window of system cycles then decides, for each input, whether it has stopped toggling.

A selection state machine in the system domain follows the live health of both inputs. When the selected input is declared dead and the other one is healthy, the selection moves to the other input. The selection can move back and forth any number of times. If both inputs are dead, the selection stays where it is. A manual request can also move the selection to the other input.

The selection drives a glitch-free two-way clock multiplexer. It uses a two-flop enable chain per input, clocked on that input's falling edge. The enable of the newly chosen input is released only after the enable of the old input has dropped, or at once if the old input is known to be dead. The block reports one bad flag per input and the current selection. Both are registered in the system domain.

Top module: `csw_switchover`

## Requirements
- R1: While `sys_rst` is high and at the first clock edge after it is released, `sel_active` is 0 (input 0 selected) and `bad_flag` is 2'b00. Both bad flags stay 0 at least until the first observation window of `WINDOW` system cycles has ended.
- R2: Bit i of `bad_flag` refers to input i. It is set at the end of an observation window during which no edge of that input reached the system domain.
- R3: A set bad flag clears at the end of a window in which edges of that input were seen. The bad flags change only on the clock edge that closes a window.
- R4: When the selected input's bad flag is 1 and the other input's flag is 0, `sel_active` changes to the other input on the following system clock edge. It does not revert when the old input recovers.
- R5: When both bad flags are 1, `sel_active` does not change, whether by automatic switching or by a manual request.
- R6: Automatic switching repeats without limit in both directions, from 0 to 1 and from 1 to 0, each time the selected input fails while the other is healthy.
- R7: A rising edge of `swap_req` (low at one clock edge, high at the next) moves `sel_active` to the other input at that edge, provided the other input's bad flag is 0. Holding `swap_req` high causes no further moves. A request made while the other input is bad has no effect.
- R8: After a handover has settled, `ref_out` equals the selected reference input. The gates of the two inputs are never open at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running supervision clock |
| sys_rst | input | 1 | Synchronous active-high reset, also sampled by the reference-domain flops |
| ref_in0 | input | 1 | Primary reference clock (input 0) |
| ref_in1 | input | 1 | Backup reference clock (input 1) |
| swap_req | input | 1 | Manual request to select the other input, acted on at its rising edge |
| ref_out | output | 1 | Glitch-free multiplexed reference clock |
| bad_flag | output | 2 | Per-input loss-of-toggle flags, bit i refers to input i |
| sel_active | output | 1 | Selected input: 0 for input 0, 1 for input 1 |

## Verification
The assertions take several properties of the inputs for granted. Both reference clocks run while reset is held. A running reference toggles slower than the system clock, and it produces several rising edges in every half window. A reference that recovers produces two falling edges before the next window closes, so its stale gate is cleared before its bad flag drops. The stimulus keeps within these limits. It uses non-commensurate reference periods of 20 ns and 22 ns, with edges that never fall on a system clock edge. It stops and restarts a reference only in the middle of a window, so a behavioural model can give the exact window in which each flag must change. Manual requests are applied on falling system edges and last at least one cycle.

// File: rtl/csw_pkg.sv
`timescale 1ns/100ps
package csw_pkg;
  typedef enum logic {
    SRC_PRI = 1'b0,
    SRC_BAK = 1'b1
  } src_e;
endpackage

// File: rtl/csw_edge_sense.sv
`timescale 1ns/100ps
// Turns activity on one reference clock into single-cycle pulses in the
// system domain: a toggle flag in the reference domain, then a synchronizer
// chain and a change detector.
module csw_edge_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic sys_rst,
  input  logic ref_clk,
  output logic edge_pulse
);
  logic                 tog_q;
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge ref_clk) begin
    if (sys_rst) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(posedge sys_clk) begin
    if (sys_rst) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], tog_q};
  end

  assign edge_pulse = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/csw_loss_detect.sv
`timescale 1ns/100ps
// Shared observation window; a flag per input records whether any edge was
// seen, and the bad flags are refreshed only when the window closes.
module csw_loss_detect #(
  parameter int WINDOW = 8,
  parameter int NUM_IN = 2
) (
  input  logic              sys_clk,
  input  logic              sys_rst,
  input  logic [NUM_IN-1:0] edge_seen,
  output logic [NUM_IN-1:0] bad
);
  localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0]     cnt_q;
  logic [NUM_IN-1:0] seen_q;
  logic [NUM_IN-1:0] bad_q;
  logic              win_end;

  assign win_end = (cnt_q == LAST);

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      cnt_q  <= '0;
      seen_q <= '0;
      bad_q  <= '0;
    end else begin
      cnt_q <= win_end ? '0 : cnt_q + 1'b1;
      if (win_end) begin
        bad_q  <= ~(seen_q | edge_seen);
        seen_q <= '0;
      end else begin
        seen_q <= seen_q | edge_seen;
      end
    end
  end

  assign bad = bad_q;

  // R3: flags only move on the edge that closes a window
  p_flags_at_window_end_r3: assert property (@(posedge sys_clk) disable iff (sys_rst)
    !$stable(bad_q) |-> $past(win_end));

  // R2: an edge anywhere in a window keeps that input good at the window's close
  p_edge_keeps_good_r2: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (win_end && edge_seen[0]) |=> !bad_q[0]);
endmodule

// File: rtl/csw_select_fsm.sv
`timescale 1ns/100ps
// Decides which input is the reference from the live bad flags and the
// manual request.
module csw_select_fsm
  import csw_pkg::*;
(
  input  logic       sys_clk,
  input  logic       sys_rst,
  input  logic [1:0] bad,
  input  logic       man_req,
  output src_e       sel
);
  src_e sel_q;
  logic man_q;
  logic cur;
  logic auto_go;
  logic man_go;

  assign cur     = sel_q;
  assign auto_go = bad[cur] && !bad[~cur];
  assign man_go  = man_req && !man_q && !bad[~cur];

  always_ff @(posedge sys_clk) begin
    if (sys_rst) begin
      sel_q <= SRC_PRI;
      man_q <= 1'b0;
    end else begin
      man_q <= man_req;
      if (auto_go || man_go) sel_q <= src_e'(~cur);
    end
  end

  assign sel = sel_q;

  // R5: both inputs lost, selection frozen
  p_hold_both_lost_r5: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (&bad) |=> $stable(sel_q));

  // R4: selected input lost while the other is good, selection moves
  p_auto_move_r4: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (bad[cur] && !bad[~cur]) |=> (sel_q != $past(sel_q)));

  // R7: a held request does not move the selection again
  p_no_retrigger_r7: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (man_req && $past(man_req) && !bad[cur]) |=> $stable(sel_q));
endmodule

// File: rtl/csw_glitchfree_mux.sv
`timescale 1ns/100ps
// Two-way clock multiplexer with a falling-edge enable chain per input.
// The new input waits for the old enable to drop unless the old input is
// known dead; a dead input's stuck enable is masked by its bad flag.
module csw_glitchfree_mux
  import csw_pkg::*;
#(
  parameter int CHAIN = 2
) (
  input  logic       sys_clk,
  input  logic       sys_rst,
  input  logic [1:0] ref_clk,
  input  src_e       sel,
  input  logic [1:0] bad,
  output logic       clk_out
);
  logic [1:0] want;
  logic [1:0] d;
  logic [1:0] en;
  logic [1:0] gate;

  assign want = {sel == SRC_BAK, sel == SRC_PRI};

  for (genvar i = 0; i < 2; i++) begin : g_leg
    localparam int J = 1 - i;
    logic [CHAIN-1:0] chain_q;

    assign d[i] = want[i] & (en[i] | ~en[J] | bad[J]);

    always_ff @(negedge ref_clk[i]) begin
      if (sys_rst) chain_q <= {CHAIN{1'(i == 0)}};
      else         chain_q <= {chain_q[CHAIN-2:0], d[i]};
    end

    assign en[i]   = chain_q[CHAIN-1];
    assign gate[i] = en[i] & ~(bad[i] & ~want[i]);
  end

  assign clk_out = |(ref_clk & gate);

  // R8: the two inputs never pass through together
  p_single_gate_r8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $onehot0(gate));
endmodule

// File: rtl/csw_switchover.sv
`timescale 1ns/100ps
module csw_switchover
  import csw_pkg::*;
#(
  parameter int WINDOW      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MUX_CHAIN   = 2
) (
  input  logic       sys_clk,
  input  logic       sys_rst,
  input  logic       ref_in0,
  input  logic       ref_in1,
  input  logic       swap_req,
  output logic       ref_out,
  output logic [1:0] bad_flag,
  output logic       sel_active
);
  logic [1:0] ref_vec;
  logic [1:0] edge_vec;
  logic [1:0] bad;
  src_e       sel;

  assign ref_vec = {ref_in1, ref_in0};

  for (genvar i = 0; i < 2; i++) begin : g_sense
    csw_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .sys_clk   (sys_clk),
      .sys_rst   (sys_rst),
      .ref_clk   (ref_vec[i]),
      .edge_pulse(edge_vec[i])
    );
  end

  csw_loss_detect #(.WINDOW(WINDOW), .NUM_IN(2)) u_loss (
    .sys_clk  (sys_clk),
    .sys_rst  (sys_rst),
    .edge_seen(edge_vec),
    .bad      (bad)
  );

  csw_select_fsm u_fsm (
    .sys_clk(sys_clk),
    .sys_rst(sys_rst),
    .bad    (bad),
    .man_req(swap_req),
    .sel    (sel)
  );

  csw_glitchfree_mux #(.CHAIN(MUX_CHAIN)) u_mux (
    .sys_clk(sys_clk),
    .sys_rst(sys_rst),
    .ref_clk(ref_vec),
    .sel    (sel),
    .bad    (bad),
    .clk_out(ref_out)
  );

  assign bad_flag   = bad;
  assign sel_active = sel;

  // R1: state right after reset
  p_reset_idle_r1: assert property (@(posedge sys_clk)
    $past(sys_rst) |-> (!sel_active && bad_flag == 2'b00));
endmodule

// File: tb/test_csw_switchover.sv
`timescale 1ns/100ps
module test_csw_switchover;
  localparam int W = 16;

  logic       sys_clk = 1'b0;
  logic       sys_rst = 1'b1;
  logic       r0 = 1'b0;
  logic       r1 = 1'b0;
  logic       swap_req = 1'b0;
  logic       ref_out;
  logic [1:0] bad_flag;
  logic       sel_active;
  logic [1:0] alive = 2'b11;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model state
  int       wcnt = 0;
  bit [1:0] mbad = 2'b00;
  bit       msel = 1'b0;
  bit       mprev = 1'b0;
  bit [1:0] alive_start = 2'b11;
  int       settle = 40;

  csw_switchover #(.WINDOW(W), .SYNC_STAGES(2), .MUX_CHAIN(2)) i_csw_switchover (
    .sys_clk   (sys_clk),
    .sys_rst   (sys_rst),
    .ref_in0   (r0),
    .ref_in1   (r1),
    .swap_req  (swap_req),
    .ref_out   (ref_out),
    .bad_flag  (bad_flag),
    .sel_active(sel_active)
  );

  always #4 sys_clk = ~sys_clk;

  initial begin
    #0.5;
    forever begin #10; if (alive[0]) r0 = ~r0; end
  end
  initial begin
    #0.3;
    forever begin #11; if (alive[1]) r1 = ~r1; end
  end

  always @(posedge sys_clk) begin
    if (sys_rst) begin
      wcnt = 0; mbad = 2'b00; msel = 1'b0; mprev = 1'b0;
      alive_start = alive; settle = 40;
    end else begin
      bit nsel;
      nsel = msel;
      if (mbad[msel] && !mbad[!msel]) nsel = !msel;
      else if (swap_req && !mprev && !mbad[!msel]) nsel = !msel;
      mprev = swap_req;
      if (wcnt == W - 1) begin
        for (int x = 0; x < 2; x++) mbad[x] = !(alive_start[x] || alive[x]);
        alive_start = alive;
        wcnt = 0;
      end else begin
        wcnt++;
      end
      if (nsel != msel) settle = 40;
      else if (settle > 0) settle--;
      msel = nsel;
    end
  end

  always @(negedge sys_clk) begin
    if (!sys_rst && !done) begin
      checks++;
      if (bad_flag !== mbad) begin
        errors++;
        $display("FAIL R2/R3 bad_flag act=%b exp=%b t=%0t", bad_flag, mbad, $time);
      end
      checks++;
      if (sel_active !== msel) begin
        errors++;
        $display("FAIL R4 sel_active act=%b exp=%b t=%0t", sel_active, msel, $time);
      end
      if (settle == 0) begin
        checks++;
        if (ref_out !== (msel ? r1 : r0)) begin
          errors++;
          $display("FAIL R8 ref_out act=%b exp=%b t=%0t", ref_out, (msel ? r1 : r0), $time);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic wait_mid();
    do @(negedge sys_clk); while (wcnt != W / 2);
  endtask

  task automatic pulse_swap(input int len);
    swap_req = 1'b1;
    cycles(len);
    swap_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    cycles(5);
    chk("R1 sel in reset", {1'b0, sel_active}, 2'b00);
    chk("R1 bad in reset", bad_flag, 2'b00);
    sys_rst = 1'b0;
    cycles(W / 2);
    chk("R1 bad before first window", bad_flag, 2'b00);
    cycles(3 * W);
    chk("R1 both running", bad_flag, 2'b00);
    chk("R8 ref_out on input 0", {1'b0, ref_out}, {1'b0, r0});

    // R2 then R4: primary stops
    wait_mid(); alive[0] = 1'b0;
    cycles(22);
    chk("R2 not before full dead window", bad_flag, 2'b00);
    cycles(2);
    chk("R2 bad0 at window close", bad_flag, 2'b01);
    chk("R4 no move yet", {1'b0, sel_active}, 2'b00);
    cycles(1);
    chk("R4 moved to backup", {1'b0, sel_active}, 2'b01);
    cycles(48);
    chk("R8 ref_out follows backup", {1'b0, ref_out}, {1'b0, r1});

    // R3: primary returns
    wait_mid(); alive[0] = 1'b1;
    cycles(7);
    chk("R3 flag held inside window", bad_flag, 2'b01);
    cycles(1);
    chk("R3 flag cleared at close", bad_flag, 2'b00);
    cycles(2 * W);
    chk("R4 no revert on recovery", {1'b0, sel_active}, 2'b01);

    // R6: backup stops, move back
    wait_mid(); alive[1] = 1'b0;
    cycles(24);
    chk("R6 bad1 set", bad_flag, 2'b10);
    cycles(1);
    chk("R6 moved back to primary", {1'b0, sel_active}, 2'b00);
    wait_mid(); alive[1] = 1'b1;
    cycles(3 * W);
    chk("R6 both good again", bad_flag, 2'b00);

    // R7: manual request, held level
    pulse_swap(6);
    chk("R7 one move on held request", {1'b0, sel_active}, 2'b01);
    cycles(2);
    pulse_swap(1);
    cycles(1);
    chk("R7 second request moves back", {1'b0, sel_active}, 2'b00);
    cycles(48);

    // R5: both stop
    wait_mid(); alive = 2'b00;
    cycles(25);
    chk("R5 both flagged", bad_flag, 2'b11);
    cycles(2 * W);
    chk("R5 selection frozen", {1'b0, sel_active}, 2'b00);
    pulse_swap(1);
    cycles(2);
    chk("R7 request ignored when other bad", {1'b0, sel_active}, 2'b00);
    wait_mid(); alive[1] = 1'b1;
    cycles(8);
    chk("R3 backup recovered", bad_flag, 2'b01);
    cycles(1);
    chk("R4 move to recovered backup", {1'b0, sel_active}, 2'b01);
    wait_mid(); alive[0] = 1'b1;
    cycles(3 * W);
    chk("R3 all recovered", bad_flag, 2'b00);

    // R6: repeated alternation
    for (int k = 0; k < 3; k++) begin
      logic cur;
      cur = sel_active;
      wait_mid(); alive[cur] = 1'b0;
      cycles(3 * W);
      chk("R6 repeated move", {1'b0, sel_active}, {1'b0, ~cur});
      wait_mid(); alive[cur] = 1'b1;
      cycles(3 * W);
    end
    cycles(48);
    chk("R8 ref_out after loops", {1'b0, ref_out}, {1'b0, (sel_active ? r1 : r0)});
    finish_run();
  end
endmodule